// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of a programmable interval timer. A load strobe sets the initial count and the operating mode. From then on the channel counts once per clock and drives a waveform output whose shape depends on the mode. The six modes are:

- an interrupt raised at terminal count;
- a gate-triggered one-shot;
- a periodic rate generator;
- a square-wave generator;
- a strobe started by a load;
- a strobe started by the gate.

The gate input acts in one of two ways, depending on the mode. In some modes it is a level enable. In the others it is a rising-edge retrigger.

A second output carries the waveform toward an interrupt line. A mask input can force that output low. The live count is visible at all times, so a caller can sample it. Counts are always binary. Host-bus decoding is left to the logic around the channel.

Top module: `pit_channel`

## Requirements
- R1: After reset, `count_out` is 0, and `wave_out` and `irq_out` are low. The channel stays idle until the first load.
- R2: A load strobe on clock edge k makes `count_out` equal to `load_val` at edge k, in every mode except square wave. A loaded value of 0 is a full count of 65536: `count_out` reads 0, and the next decrement gives 0xFFFF.
- R3: Mode code 0 (terminal-count interrupt): `wave_out` goes low on load and goes high in the cycle the count reaches 0. It stays high until the next load. The count keeps decrementing and wraps from 0 to 0xFFFF.
- R4: In mode codes 0 and 4, the gate is a level enable. The gate passes through one synchronizing register. The count stops changing from the second rising clock edge after the gate falls, and resumes from the second edge after the gate rises.
- R5: Mode code 1 (one-shot): a load drives `wave_out` low and starts counting. A synchronized gate rising edge reloads the initial count and drives `wave_out` low again. `wave_out` rises when the count reaches 0. The reload appears two clock edges after the gate rises.
- R6: Mode code 2 (rate generator): `wave_out` is low for exactly the one cycle in which the count is 1. The next edge reloads the initial count, so the period is N clocks.
- R7: Mode code 3 (square wave): the count steps down by 2, and `wave_out` toggles on every reload. For an initial count N, the high half lasts ceil(N/2) clocks and the low half lasts floor(N/2) clocks. The count shows N rounded up to even right after a load.
- R8: Mode code 4 (load-triggered strobe): `wave_out` is high after a load. It drops for exactly one cycle when the count reaches 0.
- R9: Mode code 5 (gate-triggered strobe): a synchronized gate rising edge reloads the initial count and drives `wave_out` high. `wave_out` then pulses low for one cycle when the count reaches 0.
- R10: In mode codes 2 and 3, a synchronized gate rising edge restarts the cycle from the initial count, two edges after the gate rises. In these modes the gate level has no effect.
- R11: Mode codes 6 and 7 behave exactly as mode codes 2 and 3.
- R12: `irq_out` is a registered copy of `wave_out`, one cycle later, while `irq_mask` is low. It is driven low on the edge after `irq_mask` is high. It follows `wave_out` again from the first edge after the mask is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; every edge is one count step |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Loads `load_val` and `load_mode` and restarts the channel |
| load_val | input | 16 | Initial count (0 means 65536) |
| load_mode | input | 3 | Mode code 0..7 |
| gate | input | 1 | Gate: level enable or edge retrigger, depending on the mode |
| irq_mask | input | 1 | High forces `irq_out` low |
| count_out | output | 16 | Live count value |
| wave_out | output | 1 | Mode waveform |
| irq_out | output | 1 | Masked, registered copy of `wave_out` |

## Verification
The count and the waveform are registered, so a load shows its value one edge after the strobe is sampled. After that, each further edge moves the count by one step. A gate change needs two edges: the first fills the synchronizing register and the second acts on the counter. `irq_out` trails `wave_out` by one more edge. The bench drives inputs on falling edges and samples right after the following falling edges. It advances an exact number of edges before each comparison, so every expected value is fixed by counting edges from the stimulus.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [2:0] {
    MD_TC_IRQ  = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SW_STB  = 3'd4,
    MD_HW_STB  = 3'd5
  } chan_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic chan_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return chan_mode_e'({1'b0, code[1:0]});
    return chan_mode_e'(code);
  endfunction

endpackage

// File: rtl/pit_gate_sense.sv
module pit_gate_sense (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  output logic gate_lvl,
  output logic gate_rise
);
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= gate_in;
      prev_q <= sync_q;
    end
  end

  assign gate_lvl  = sync_q;
  assign gate_rise = sync_q & ~prev_q;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       load_mode,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  output logic [CNT_W-1:0] count_out,
  output logic             wave_out,
  output chan_mode_e       mode_out
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] WRAP = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  chan_mode_e    mode_q, mode_n;
  logic [CW-1:0] init_q, init_n;
  logic [CW-1:0] cnt_q,  cnt_n;
  logic          wave_q, wave_n;
  logic          run_q,  run_n;
  logic [CW-1:0] ld_init;
  chan_mode_e    ld_mode;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return (v == '0) ? WRAP : v - ONE;
  endfunction

  // high half start: round odd counts up to even
  function automatic logic [CW-1:0] high_start(input logic [CW-1:0] n);
    return n + {{CNT_W{1'b0}}, n[0]};
  endfunction

  // low half start: round odd counts down, never below one step
  function automatic logic [CW-1:0] low_start(input logic [CW-1:0] n);
    logic [CW-1:0] t;
    t = n - {{CNT_W{1'b0}}, n[0]};
    return (t == '0) ? TWO : t;
  endfunction

  assign ld_init = (load_val == '0) ? FULL : {1'b0, load_val};
  assign ld_mode = fold_mode(load_mode);

  always_comb begin
    mode_n = mode_q;
    init_n = init_q;
    cnt_n  = cnt_q;
    wave_n = wave_q;
    run_n  = run_q;
    if (load_stb) begin
      mode_n = ld_mode;
      init_n = ld_init;
      run_n  = 1'b1;
      case (ld_mode)
        MD_TC_IRQ, MD_ONESHOT: begin
          cnt_n  = ld_init;
          wave_n = 1'b0;
        end
        MD_RATE: begin
          cnt_n  = ld_init;
          wave_n = (ld_init != ONE);
        end
        MD_SQUARE: begin
          cnt_n  = high_start(ld_init);
          wave_n = 1'b1;
        end
        default: begin
          cnt_n  = ld_init;
          wave_n = 1'b1;
        end
      endcase
    end else if (run_q) begin
      case (mode_q)
        MD_TC_IRQ: begin
          if (gate_lvl) begin
            cnt_n = step_down(cnt_q);
            if (cnt_n == '0) wave_n = 1'b1;
          end
        end
        MD_ONESHOT: begin
          if (gate_rise) begin
            cnt_n  = init_q;
            wave_n = 1'b0;
          end else begin
            cnt_n = step_down(cnt_q);
            if (cnt_n == '0) wave_n = 1'b1;
          end
        end
        MD_RATE: begin
          if (gate_rise || cnt_q == ONE) cnt_n = init_q;
          else                           cnt_n = step_down(cnt_q);
          wave_n = (cnt_n != ONE);
        end
        MD_SQUARE: begin
          if (gate_rise) begin
            cnt_n  = high_start(init_q);
            wave_n = 1'b1;
          end else if (cnt_q <= TWO) begin
            wave_n = ~wave_q;
            cnt_n  = wave_q ? low_start(init_q) : high_start(init_q);
          end else begin
            cnt_n = cnt_q - TWO;
          end
        end
        MD_SW_STB: begin
          if (gate_lvl) begin
            cnt_n  = step_down(cnt_q);
            wave_n = (cnt_n != '0);
          end else begin
            wave_n = 1'b1;
          end
        end
        default: begin
          if (gate_rise) begin
            cnt_n  = init_q;
            wave_n = 1'b1;
          end else begin
            cnt_n  = step_down(cnt_q);
            wave_n = (cnt_n != '0);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_TC_IRQ;
      init_q <= FULL;
      cnt_q  <= '0;
      wave_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      init_q <= init_n;
      cnt_q  <= cnt_n;
      wave_q <= wave_n;
      run_q  <= run_n;
    end
  end

  assign count_out = cnt_q[CNT_W-1:0];
  assign wave_out  = wave_q;
  assign mode_out  = mode_q;
endmodule

// File: rtl/pit_irq_gate.sv
module pit_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic wave_in,
  input  logic mask_in,
  output logic irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= wave_in & ~mask_in;
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       load_mode,
  input  logic             gate,
  input  logic             irq_mask,
  output logic [CNT_W-1:0] count_out,
  output logic             wave_out,
  output logic             irq_out
);
  logic       gate_lvl;
  logic       gate_rise;
  chan_mode_e cur_mode;

  pit_gate_sense u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_in   (gate),
    .gate_lvl  (gate_lvl),
    .gate_rise (gate_rise)
  );

  pit_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .load_mode (load_mode),
    .gate_lvl  (gate_lvl),
    .gate_rise (gate_rise),
    .count_out (count_out),
    .wave_out  (wave_out),
    .mode_out  (cur_mode)
  );

  pit_irq_gate u_irq (
    .clk     (clk),
    .rst     (rst),
    .wave_in (wave_out),
    .mask_in (irq_mask),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load_stb,
  input logic [CNT_W-1:0] load_val,
  input logic [2:0]       load_mode,
  input logic             irq_mask,
  input logic [CNT_W-1:0] count_out,
  input logic             wave_out,
  input logic             irq_out,
  input logic             gate_lvl,
  input logic [2:0]       cur_mode
);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_mode[1:0] != 2'b11) |=> count_out == $past(load_val));

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_out);

  // R12
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_mask |=> irq_out == $past(wave_out));

  // R3
  tc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && cur_mode == 3'd0 && wave_out) |=> wave_out);

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && cur_mode == 3'd0 && !gate_lvl) |=> $stable(count_out));

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && cur_mode == 3'd4 && !wave_out) |=> wave_out);
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_stb  (load_stb),
  .load_val  (load_val),
  .load_mode (load_mode),
  .irq_mask  (irq_mask),
  .count_out (count_out),
  .wave_out  (wave_out),
  .irq_out   (irq_out),
  .gate_lvl  (gate_lvl),
  .cur_mode  (cur_mode)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  load_mode = '0;
  logic        gate = 1'b0;
  logic        irq_mask = 1'b0;
  logic [15:0] count_out;
  logic        wave_out;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(load_val),
    .load_mode(load_mode), .gate(gate), .irq_mask(irq_mask),
    .count_out(count_out), .wave_out(wave_out), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] v, input logic [2:0] m);
    load_stb = 1'b1; load_val = v; load_mode = m;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", 32'(count_out), 0);
    chk("R1 wave", 32'(wave_out), 0);
    chk("R1 irq", 32'(irq_out), 0);
    step(3);
    chk("R1 idle count", 32'(count_out), 0);
  endtask

  task automatic t_mode0;
    gate = 1'b1; step(3);
    do_load(16'd5, 3'd0);
    chk("R2 load value", 32'(count_out), 5);
    chk("R3 wave low on load", 32'(wave_out), 0);
    step(4);
    chk("R3 count 1", 32'(count_out), 1);
    chk("R3 still low", 32'(wave_out), 0);
    step(1);
    chk("R3 count 0", 32'(count_out), 0);
    chk("R3 wave high at tc", 32'(wave_out), 1);
    step(1);
    chk("R3 wrap", 32'(count_out), 32'hFFFF);
    chk("R3 sticky", 32'(wave_out), 1);
    chk("R12 irq follows", 32'(irq_out), 1);
    do_load(16'd0, 3'd0);
    chk("R2 zero load", 32'(count_out), 0);
    step(1);
    chk("R2 full count", 32'(count_out), 32'hFFFF);
    chk("R2 full count wave", 32'(wave_out), 0);
  endtask

  task automatic t_gate_hold;
    do_load(16'd100, 3'd0);
    gate = 1'b0;
    step(1);
    chk("R4 one more step", 32'(count_out), 99);
    step(3);
    chk("R4 held", 32'(count_out), 99);
    gate = 1'b1;
    step(1);
    chk("R4 still held", 32'(count_out), 99);
    step(1);
    chk("R4 resumed", 32'(count_out), 98);
  endtask

  task automatic t_mode1;
    gate = 1'b0; step(3);
    do_load(16'd4, 3'd1);
    chk("R5 load low", 32'(wave_out), 0);
    step(4);
    chk("R5 tc high", 32'(wave_out), 1);
    gate = 1'b1;
    step(1);
    chk("R5 before retrigger", 32'(count_out), 32'hFFFF);
    step(1);
    chk("R5 retrigger count", 32'(count_out), 4);
    chk("R5 retrigger low", 32'(wave_out), 0);
    step(4);
    chk("R5 tc again", 32'(wave_out), 1);
  endtask

  task automatic t_mode2;
    do_load(16'd3, 3'd2);
    chk("R6 load", 32'(wave_out), 1);
    step(1);
    chk("R6 count 2", 32'(count_out), 2);
    step(1);
    chk("R6 low at 1", 32'(wave_out), 0);
    step(1);
    chk("R6 reload", 32'(count_out), 3);
    chk("R6 high after reload", 32'(wave_out), 1);
    do_load(16'd5, 3'd2);
    gate = 1'b0; step(2);
    chk("R10 gate low ignored", 32'(count_out), 3);
    gate = 1'b1; step(1);
    chk("R10 before restart", 32'(count_out), 2);
    step(1);
    chk("R10 restart", 32'(count_out), 5);
  endtask

  task automatic t_square(input logic [15:0] n, input logic [2:0] m,
                          input int len, input logic [15:0] pat, input string req);
    logic [15:0] got;
    got = '0;
    do_load(n, m);
    chk(req, 32'(count_out), 32'(n + 16'(n[0])));
    for (int i = 0; i < len; i++) begin
      got[len-1-i] = wave_out;
      step(1);
    end
    chk(req, 32'(got), 32'(pat));
  endtask

  task automatic t_mode4;
    do_load(16'd3, 3'd4);
    chk("R8 load high", 32'(wave_out), 1);
    step(2);
    chk("R8 before pulse", 32'(wave_out), 1);
    step(1);
    chk("R8 pulse", 32'(wave_out), 0);
    step(1);
    chk("R8 after pulse", 32'(wave_out), 1);
  endtask

  task automatic t_mode5;
    do_load(16'd3, 3'd5);
    step(3);
    chk("R9 pulse", 32'(wave_out), 0);
    step(1);
    chk("R9 after pulse", 32'(wave_out), 1);
    gate = 1'b0; step(2);
    gate = 1'b1; step(2);
    chk("R9 trigger count", 32'(count_out), 3);
    chk("R9 trigger high", 32'(wave_out), 1);
    step(3);
    chk("R9 pulse after trigger", 32'(wave_out), 0);
  endtask

  task automatic t_alias6;
    do_load(16'd2, 3'd6);
    chk("R11 mode6 load", 32'(wave_out), 1);
    step(1);
    chk("R11 mode6 low at 1", 32'(wave_out), 0);
    step(1);
    chk("R11 mode6 reload", 32'(count_out), 2);
  endtask

  task automatic t_irq;
    irq_mask = 1'b1;
    do_load(16'd2, 3'd4);
    step(1);
    chk("R12 masked", 32'(irq_out), 0);
    chk("R12 wave while masked", 32'(wave_out), 1);
    irq_mask = 1'b0;
    step(1);
    chk("R12 unmasked", 32'(irq_out), 1);
    step(1);
    chk("R12 follows pulse", 32'(irq_out), 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset;
    t_mode0;
    t_gate_hold;
    t_mode1;
    t_mode2;
    t_square(16'd5, 3'd3, 10, 16'b1110011100, "R7 square odd");
    t_square(16'd4, 3'd7, 8, 16'b11001100, "R11 mode7 square");
    t_mode4;
    t_mode5;
    t_alias6;
    t_irq;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule